// File: doc/BRIEF.md
# Lane Instruction Sequencer

This block walks a chain of up to sixteen lane-control instructions on behalf of a serial display link controller. Every instruction slot stores a lane mode, an escape entry code, a packet kind, a clock-lane enable and four data-lane enables. The slot that is currently active drives those values onto the outputs. A successor table, programmed by software, picks the slot that follows each one. A single counted jump sends one chosen slot back to a target slot a programmed number of times before the chain goes on through the successor table.

Software fills the slots, the successor table and the jump settings through a word-wide configuration port. It then writes 1 to the run bit. The walk always begins at slot 0, which is the link stop-state instruction. The active slot hands over to its successor only when the lane model raises that slot's done input. When the chain reaches ID 15 (END), the hardware clears the run bit itself. Writing 0 to the run bit cancels a walk in progress. Two dwell registers, each holding two 12-bit counts, are also kept for the lane timers.

Top module: `lane_instr_seq`

## Requirements
- R1: After reset the sequencer is idle, the run bit reads 0, `cur_slot` is 0, and every slot, table, jump and dwell register reads 0.
- R2: A slot word at address 16+k stores the mode [31:28], escape code [27:24], packet kind [23:20], clock-lane enable [4] and data-lane enables [3:0]. Bits 19:5 read back as 0. While slot k is active, `lane_mode`, `esc_code`, `pkt_kind`, `clk_lane_en` and `data_lane_en` equal those fields.
- R3: Writing 1 to bit 0 of address 0 while idle starts a walk at slot 0. From the next clock edge, `seq_busy` is 1 and bit 0 of address 0 reads 1.
- R4: The successor of slot k is the 4-bit field at bit offset 4×k of a 64-bit table. Address 2 holds slots 0 to 7 and address 3 holds slots 8 to 15.
- R5: The active slot changes only on a clock edge where `slot_done[cur_slot]` is 1. The done inputs of other slots have no effect.
- R6: When the next slot would be ID 15 (END), the walk ends at that edge: `seq_busy` drops, the run bit reads 0 and `cur_slot` returns to 0.
- R7: Address 4 holds a repeat count [15:0], a jump point [19:16] and a jump target [23:20]. When the jump point finishes with a nonzero remaining count, the walk goes to the target and the count drops by one. Otherwise the walk follows the successor table. A count of 0 never jumps.
- R8: Every new start reloads the remaining count from address 4, so repeated runs repeat the same walk.
- R9: Writing 0 to bit 0 of address 0 during a walk ends it at that edge and returns the outputs to idle.
- R10: Writing 1 to the run bit during a walk leaves the active slot unchanged.
- R11: Addresses 5 and 6 each hold dwell counts N0 [11:0] and N1 [27:16]. Their other bits read 0. Unmapped addresses read 0 and ignore writes.
- R12: While idle, all lane control outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| slot_done | input | 16 | Per-slot completion from the lane model |
| seq_busy | output | 1 | Walk in progress |
| cur_slot | output | 4 | Active slot ID (0 while idle) |
| lane_mode | output | 4 | Mode of the active slot |
| esc_code | output | 4 | Escape entry code of the active slot |
| pkt_kind | output | 4 | Packet kind of the active slot |
| clk_lane_en | output | 1 | Clock-lane enable of the active slot |
| data_lane_en | output | 4 | Data-lane enables of the active slot |

## Verification
The hardest situation to reach is the counted jump running out. The jump point has to be visited once more than the repeat count, and the walk must then take the normal successor. A second run must show that the count was reloaded rather than left at zero. The stimulus builds a chain whose jump point loops back through an intermediate slot twice. It holds every done input high so that each cycle exposes one slot, and it compares the full visit order. The same walk is then repeated, and it is run once more with a zero count. A separate case keeps every done input high except that of the active slot, to show that only the active slot's done input can move the walk.

// File: rtl/lseq_pkg.sv
package lseq_pkg;
   localparam int WORD_W    = 32;
   localparam int FLD_W     = 4;
   localparam int MODE_LSB  = 28;
   localparam int ESC_LSB   = 24;
   localparam int PKT_LSB   = 20;
   localparam int CLKEN_BIT = 4;
   localparam int DLANE_W   = 4;
   localparam int JPT_LSB   = 16;
   localparam int JTGT_LSB  = 20;
   localparam int N1_LSB    = 16;

   typedef enum logic [FLD_W-1:0] {
      LM_STOP = 4'd0, LM_HS = 4'd1, LM_ESC = 4'd2,
      LM_HSCX = 4'd3, LM_TURN = 4'd4, LM_NOP = 4'd5
   } lane_mode_e;

   typedef enum logic [FLD_W-1:0] {
      PK_PIXEL = 4'd0, PK_CMD = 4'd1
   } pkt_kind_e;

   typedef struct packed {
      logic [FLD_W-1:0]   mode;
      logic [FLD_W-1:0]   esc;
      logic [FLD_W-1:0]   pkt;
      logic               clk_en;
      logic [DLANE_W-1:0] dlane;
   } slot_t;

   function automatic logic [WORD_W-1:0] slot_to_word(slot_t s);
      logic [WORD_W-1:0] w;
      w = '0;
      w[MODE_LSB +: FLD_W] = s.mode;
      w[ESC_LSB  +: FLD_W] = s.esc;
      w[PKT_LSB  +: FLD_W] = s.pkt;
      w[CLKEN_BIT]         = s.clk_en;
      w[0 +: DLANE_W]      = s.dlane;
      return w;
   endfunction
endpackage

// File: rtl/lseq_cfg.sv
module lseq_cfg
   import lseq_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   parameter int ID_W      = 4,
   parameter int CNT_W     = 16,
   parameter int LOOP_W    = 12
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [ID_W:0]               addr,
   input  logic [WORD_W-1:0]           wdata,
   input  logic                        running,
   output logic [WORD_W-1:0]           rdata,
   output slot_t [NUM_SLOTS-1:0]       slots,
   output logic [NUM_SLOTS*ID_W-1:0]   nxt_tab,
   output logic [ID_W-1:0]             jmp_point,
   output logic [ID_W-1:0]             jmp_target,
   output logic [CNT_W-1:0]            jmp_count,
   output logic                        start_req,
   output logic                        stop_req
);
   localparam int TAB_W      = NUM_SLOTS * ID_W;
   localparam int TAB_WORDS  = TAB_W / WORD_W;
   localparam int ADDR_TAB0  = 2;
   localparam int ADDR_JMP   = ADDR_TAB0 + TAB_WORDS;
   localparam int ADDR_LOOP0 = ADDR_JMP + 1;
   localparam int LOOP_REGS  = 2;

   logic [ID_W-1:0]   idx;
   logic              low_page;
   logic [WORD_W-1:0] tab_q  [TAB_WORDS];
   logic [LOOP_W-1:0] n0_q   [LOOP_REGS];
   logic [LOOP_W-1:0] n1_q   [LOOP_REGS];

   assign idx       = addr[ID_W-1:0];
   assign low_page  = ~addr[ID_W];
   assign start_req = we & low_page & (idx == '0) &  wdata[0];
   assign stop_req  = we & low_page & (idx == '0) & ~wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slots      <= '0;
         jmp_point  <= '0;
         jmp_target <= '0;
         jmp_count  <= '0;
         for (int t = 0; t < TAB_WORDS; t++) tab_q[t] <= '0;
         for (int r = 0; r < LOOP_REGS; r++) begin
            n0_q[r] <= '0;
            n1_q[r] <= '0;
         end
      end else if (we) begin
         if (addr[ID_W]) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
               if (idx == ID_W'(s)) begin
                  slots[s].mode   <= wdata[MODE_LSB +: FLD_W];
                  slots[s].esc    <= wdata[ESC_LSB  +: FLD_W];
                  slots[s].pkt    <= wdata[PKT_LSB  +: FLD_W];
                  slots[s].clk_en <= wdata[CLKEN_BIT];
                  slots[s].dlane  <= wdata[0 +: DLANE_W];
               end
            end
         end else begin
            for (int t = 0; t < TAB_WORDS; t++)
               if (idx == ID_W'(ADDR_TAB0 + t)) tab_q[t] <= wdata;
            if (idx == ID_W'(ADDR_JMP)) begin
               jmp_count  <= wdata[0 +: CNT_W];
               jmp_point  <= wdata[JPT_LSB  +: ID_W];
               jmp_target <= wdata[JTGT_LSB +: ID_W];
            end
            for (int r = 0; r < LOOP_REGS; r++) begin
               if (idx == ID_W'(ADDR_LOOP0 + r)) begin
                  n0_q[r] <= wdata[0 +: LOOP_W];
                  n1_q[r] <= wdata[N1_LSB +: LOOP_W];
               end
            end
         end
      end
   end

   always_comb begin
      for (int t = 0; t < TAB_WORDS; t++) nxt_tab[t*WORD_W +: WORD_W] = tab_q[t];
   end

   always_comb begin
      rdata = '0;
      if (addr[ID_W]) begin
         rdata = slot_to_word(slots[idx]);
      end else begin
         if (idx == '0) rdata[0] = running;
         for (int t = 0; t < TAB_WORDS; t++)
            if (idx == ID_W'(ADDR_TAB0 + t)) rdata = tab_q[t];
         if (idx == ID_W'(ADDR_JMP)) begin
            rdata[0 +: CNT_W]     = jmp_count;
            rdata[JPT_LSB +: ID_W]  = jmp_point;
            rdata[JTGT_LSB +: ID_W] = jmp_target;
         end
         for (int r = 0; r < LOOP_REGS; r++) begin
            if (idx == ID_W'(ADDR_LOOP0 + r)) begin
               rdata[0 +: LOOP_W]      = n0_q[r];
               rdata[N1_LSB +: LOOP_W] = n1_q[r];
            end
         end
      end
   end
endmodule

// File: rtl/lseq_walker.sv
module lseq_walker #(
   parameter int NUM_SLOTS = 16,
   parameter int ID_W      = 4,
   parameter int CNT_W     = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_req,
   input  logic                      stop_req,
   input  logic [NUM_SLOTS-1:0]      slot_done,
   input  logic [NUM_SLOTS*ID_W-1:0] nxt_tab,
   input  logic [ID_W-1:0]           jmp_point,
   input  logic [ID_W-1:0]           jmp_target,
   input  logic [CNT_W-1:0]          jmp_count,
   output logic                      running,
   output logic [ID_W-1:0]           cur
);
   localparam logic [ID_W-1:0] END_ID = ID_W'(NUM_SLOTS - 1);

   logic [CNT_W-1:0] remain;
   logic             done_cur;
   logic             take_jump;
   logic [ID_W-1:0]  succ;
   logic [ID_W-1:0]  dest;

   assign done_cur  = slot_done[cur];
   assign succ      = nxt_tab[cur*ID_W +: ID_W];
   assign take_jump = (cur == jmp_point) && (remain != '0);
   assign dest      = take_jump ? jmp_target : succ;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cur     <= '0;
         remain  <= '0;
      end else if (!running) begin
         if (start_req) begin
            running <= 1'b1;
            cur     <= '0;
            remain  <= jmp_count;
         end
      end else if (stop_req) begin
         running <= 1'b0;
         cur     <= '0;
      end else if (done_cur) begin
         if (take_jump) remain <= remain - CNT_W'(1);
         if (dest == END_ID) begin
            running <= 1'b0;
            cur     <= '0;
         end else begin
            cur <= dest;
         end
      end
   end

   p_launch_slot0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && start_req) |=> (running && cur == '0));
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !done_cur && !stop_req) |=> (running && $stable(cur)));
   p_never_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cur != END_ID));
   p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running)) |-> (remain <= $past(remain)));
   p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (running && stop_req) |=> !running);
   p_restart_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (running && start_req && !done_cur) |=> (running && $stable(cur)));
endmodule

// File: rtl/lseq_drive.sv
module lseq_drive
   import lseq_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   parameter int ID_W      = 4,
   parameter bit IDLE_PARK = 1'b0
) (
   input  slot_t [NUM_SLOTS-1:0] slots,
   input  logic                  running,
   input  logic [ID_W-1:0]       cur,
   output logic [FLD_W-1:0]      lane_mode,
   output logic [FLD_W-1:0]      esc_code,
   output logic [FLD_W-1:0]      pkt_kind,
   output logic                  clk_lane_en,
   output logic [DLANE_W-1:0]    data_lane_en
);
   slot_t act;

   generate
      if (IDLE_PARK) begin : g_park
         assign act = running ? slots[cur] : slots[0];
      end else begin : g_quiet
         assign act = running ? slots[cur] : '0;
      end
   endgenerate

   assign lane_mode    = act.mode;
   assign esc_code     = act.esc;
   assign pkt_kind     = act.pkt;
   assign clk_lane_en  = act.clk_en;
   assign data_lane_en = act.dlane;
endmodule

// File: rtl/lane_instr_seq.sv
module lane_instr_seq
   import lseq_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   parameter int CNT_W     = 16,
   parameter int LOOP_W    = 12,
   parameter bit IDLE_PARK = 1'b0,
   localparam int ID_W     = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [ID_W:0]        cfg_addr,
   input  logic [WORD_W-1:0]    cfg_wdata,
   output logic [WORD_W-1:0]    cfg_rdata,
   input  logic [NUM_SLOTS-1:0] slot_done,
   output logic                 seq_busy,
   output logic [ID_W-1:0]      cur_slot,
   output logic [FLD_W-1:0]     lane_mode,
   output logic [FLD_W-1:0]     esc_code,
   output logic [FLD_W-1:0]     pkt_kind,
   output logic                 clk_lane_en,
   output logic [DLANE_W-1:0]   data_lane_en
);
   generate
      if (NUM_SLOTS != 16) begin : g_bad_slots
         $error("NUM_SLOTS must be 16: slot IDs are 4-bit fields");
      end
      if (CNT_W < 1 || CNT_W > JPT_LSB) begin : g_bad_cnt
         $error("CNT_W must fit below the jump point field");
      end
      if (LOOP_W < 1 || LOOP_W > N1_LSB) begin : g_bad_loop
         $error("LOOP_W must fit below the N1 field");
      end
   endgenerate

   slot_t [NUM_SLOTS-1:0]      slots;
   logic [NUM_SLOTS*ID_W-1:0]  nxt_tab;
   logic [ID_W-1:0]            jmp_point, jmp_target;
   logic [CNT_W-1:0]           jmp_count;
   logic                       start_req, stop_req;

   lseq_cfg #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .CNT_W(CNT_W), .LOOP_W(LOOP_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .running(seq_busy), .rdata(cfg_rdata), .slots(slots), .nxt_tab(nxt_tab),
      .jmp_point(jmp_point), .jmp_target(jmp_target), .jmp_count(jmp_count),
      .start_req(start_req), .stop_req(stop_req)
   );

   lseq_walker #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .CNT_W(CNT_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
      .slot_done(slot_done), .nxt_tab(nxt_tab), .jmp_point(jmp_point),
      .jmp_target(jmp_target), .jmp_count(jmp_count),
      .running(seq_busy), .cur(cur_slot)
   );

   lseq_drive #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .IDLE_PARK(IDLE_PARK)) u_drive (
      .slots(slots), .running(seq_busy), .cur(cur_slot),
      .lane_mode(lane_mode), .esc_code(esc_code), .pkt_kind(pkt_kind),
      .clk_lane_en(clk_lane_en), .data_lane_en(data_lane_en)
   );
endmodule

// File: tb/tb_lane_instr_seq.sv
module tb_lane_instr_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we;
   logic [4:0]  cfg_addr;
   logic [31:0] cfg_wdata, cfg_rdata;
   logic [15:0] slot_done;
   logic        seq_busy, clk_lane_en;
   logic [3:0]  cur_slot, lane_mode, esc_code, pkt_kind, data_lane_en;
   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   lane_instr_seq dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .slot_done(slot_done),
      .seq_busy(seq_busy), .cur_slot(cur_slot), .lane_mode(lane_mode),
      .esc_code(esc_code), .pkt_kind(pkt_kind), .clk_lane_en(clk_lane_en),
      .data_lane_en(data_lane_en)
   );

   // {address, write data, expected readback}
   localparam int NV = 11;
   localparam logic [68:0] VEC [NV] = '{
      {5'd16, 32'h0F0A_BC1F, 32'h0F00_001F},
      {5'd17, 32'h3510_0E02, 32'h3510_0002},
      {5'd18, 32'h2C0F_FFF5, 32'h2C00_0015},
      {5'd19, 32'h5A11_2348, 32'h5A10_0008},
      {5'd31, 32'hFFFF_FFFF, 32'hFFF0_001F},
      {5'd2,  32'h0000_13F3, 32'h0000_13F3},
      {5'd3,  32'hFFFF_FFFF, 32'hFFFF_FFFF},
      {5'd4,  32'hAB23_0002, 32'h0023_0002},
      {5'd5,  32'hFFFF_FFFF, 32'h0FFF_0FFF},
      {5'd6,  32'h1234_5678, 32'h0234_0678},
      {5'd1,  32'hFFFF_FFFF, 32'h0000_0000}
   };
   localparam int SEQ_JUMP [7] = '{0, 3, 2, 3, 2, 3, 1};
   localparam int SEQ_FLAT [7] = '{0, 3, 1, 0, 0, 0, 0};

   task automatic chk_eq(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(logic [4:0] a, output logic [31:0] d);
      cfg_addr = a;
      #1;
      d = cfg_rdata;
   endtask

   function automatic logic [31:0] slot_exp(int k);
      case (k)
         0: return 32'h0F00_001F;
         1: return 32'h3510_0002;
         2: return 32'h2C00_0015;
         3: return 32'h5A10_0008;
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk_slot(int k, string req);
      logic [31:0] e;
      e = slot_exp(k);
      chk_eq({req, " slot"}, {28'b0, cur_slot}, k);
      chk_eq({req, " fields"},
             {15'b0, lane_mode, esc_code, pkt_kind, clk_lane_en, data_lane_en},
             {15'b0, e[31:20], e[4:0]});
   endtask

   task automatic chk_idle(string req);
      chk_eq({req, " busy"}, {31'b0, seq_busy}, 32'd0);
      chk_eq({req, " slot"}, {28'b0, cur_slot}, 32'd0);
      chk_eq({req, " R12 outputs"},
             {15'b0, lane_mode, esc_code, pkt_kind, clk_lane_en, data_lane_en}, 32'd0);
   endtask

   task automatic run_chain(int seq[7], int len, string req);
      logic [31:0] d;
      wr(5'd0, 32'd1);
      chk_eq("R3 busy", {31'b0, seq_busy}, 32'd1);
      rd(5'd0, d);
      chk_eq("R3 run bit", d, 32'd1);
      chk_slot(0, "R2");
      repeat (2) @(negedge clk);
      chk_slot(0, "R5 hold");
      slot_done = 16'hFFFF;
      for (int i = 1; i < len; i++) begin
         @(negedge clk);
         chk_slot(seq[i], req);
      end
      @(negedge clk);
      chk_idle("R6");
      rd(5'd0, d);
      chk_eq("R6 run bit", d, 32'd0);
      slot_done = 16'h0000;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; slot_done = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk_idle("R1");
      rd(5'd0, d);  chk_eq("R1 ctrl", d, 32'd0);
      rd(5'd16, d); chk_eq("R1 slot0", d, 32'd0);
      rd(5'd4, d);  chk_eq("R1 jump", d, 32'd0);
      rd(5'd5, d);  chk_eq("R1 dwell", d, 32'd0);

      // register vector table: R2 slots, R4 table, R7 jump, R11 dwell/unmapped
      for (int v = 0; v < NV; v++) begin
         wr(VEC[v][68:64], VEC[v][63:32]);
         rd(VEC[v][68:64], d);
         if (VEC[v][68:64] >= 5'd16)     chk_eq("R2 readback", d, VEC[v][31:0]);
         else if (VEC[v][68:64] <= 5'd3 && VEC[v][68:64] >= 5'd2)
                                         chk_eq("R4 readback", d, VEC[v][31:0]);
         else if (VEC[v][68:64] == 5'd4) chk_eq("R7 readback", d, VEC[v][31:0]);
         else                            chk_eq("R11 readback", d, VEC[v][31:0]);
      end
      chk_idle("R12 idle after config");

      // counted jump twice, then again to show reload
      run_chain(SEQ_JUMP, 7, "R7 jump walk");
      run_chain(SEQ_JUMP, 7, "R8 reload walk");
      // zero count never jumps
      wr(5'd4, 32'h0023_0000);
      run_chain(SEQ_FLAT, 3, "R7 zero count");

      // R4 / R5 / R10 / R9 directed
      wr(5'd0, 32'd1);
      slot_done = 16'h0001;
      @(negedge clk);
      slot_done = 16'h0000;
      chk_slot(3, "R4 successor");
      slot_done = ~16'h0008;
      repeat (2) @(negedge clk);
      chk_slot(3, "R5 other done");
      slot_done = 16'h0000;
      wr(5'd0, 32'd1);
      chk_slot(3, "R10 restart");
      chk_eq("R10 busy", {31'b0, seq_busy}, 32'd1);
      wr(5'd0, 32'd0);
      chk_idle("R9 abort");
      rd(5'd0, d);
      chk_eq("R9 run bit", d, 32'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule